// File: doc/BRIEF.md
# Interval Timer with Interrupt

This block is a down-counting interval timer attached to a small memory-mapped register bus. Software programs a reload value, chooses one of two tick sources and chooses either periodic reload or free-running wrap. Once enabled, the counter steps down by one on each active tick of the chosen source. When a tick arrives while the count is already zero, the block raises a level interrupt. That interrupt stays high until software writes to a dedicated acknowledge register.

The bus is a single-cycle strobe interface. A write takes effect at the clock edge where `wr_en` is high. A read returns data combinationally while `rd_en` is high. The block has no streaming data path, so it has no valid/ready handshake and every pin is a plain control or status signal. The two tick inputs are clock-enable strobes, one cycle wide, that are produced elsewhere.

Top module: `interval_timer`

## Requirements
- R1: After reset, the reload value, the count, the control bits and `irq` are all zero.
- R2: The reload value is read and written at offset 0x0, and the count is read at offset 0x4. Control is read and written at offset 0x8, with bit 0 = enable, bit 1 = mode (1 periodic, 0 free-running) and bit 4 = tick select (0 `tick_a`, 1 `tick_b`). All other control bits read back as zero. Offset 0xC reads as zero, and `rd_data` is zero while `rd_en` is low.
- R3: A write to offset 0x4 leaves the count unchanged.
- R4: The count changes on a tick only when enable is 1 and the selected tick strobe is high. The unselected strobe has no effect.
- R5: In periodic mode, a tick at count zero loads the count from the reload value.
- R6: In free-running mode, a tick at count zero wraps the count to 0xFFFFFFFF. Every other tick decrements it by one.
- R7: A reload write while enabled puts the written value in the count on the next cycle. This write overrides a tick in the same cycle, and that tick raises no interrupt. A reload write while disabled leaves the count unchanged.
- R8: A tick taken at count zero sets `irq` on the next cycle. `irq` then holds its level until it is cleared.
- R9: Any write to offset 0xC clears `irq` on the next cycle, whatever the data value.
- R10: If a zero event and a write to 0xC occur in the same cycle, `irq` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational |
| tick_a | input | 1 | Tick strobe, source 0 |
| tick_b | input | 1 | Tick strobe, source 1 |
| irq | output | 1 | Level interrupt |

## Verification
A wrong count becomes visible in the next read of offset 0x4. It also shows as an early or late `irq` one cycle after the tick that should have taken the count through zero. A corrupted control or reload register shows up in the read-back immediately, and it also changes the number of ticks between interrupts. The bench sweeps reload values and both tick sources and counts the exact number of ticks to each interrupt. The sweep puts a stray tick on the unselected source between every pair of real ticks, so a wrong select or enable gate changes the count it reads.

// File: rtl/itimer_pkg.sv
package itimer_pkg;
  localparam logic [3:0] OFS_LOAD  = 4'h0;
  localparam logic [3:0] OFS_VALUE = 4'h4;
  localparam logic [3:0] OFS_CTRL  = 4'h8;
  localparam logic [3:0] OFS_CLEAR = 4'hC;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MODE_BIT = 1;
  localparam int CTRL_SEL_BIT  = 4;

  typedef struct packed {
    logic sel;
    logic periodic;
    logic en;
  } tmr_ctrl_t;
endpackage

// File: rtl/itimer_regs.sv
module itimer_regs
  import itimer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] load_q,
  output tmr_ctrl_t         ctrl,
  output logic              load_wr,
  output logic              clr_wr,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [DATA_W-1:0] CTRL_MASK =
    (DATA_W'(1) << CTRL_EN_BIT) | (DATA_W'(1) << CTRL_MODE_BIT) | (DATA_W'(1) << CTRL_SEL_BIT);

  logic [3:0] ofs;
  logic       ctrl_wr;
  logic [DATA_W-1:0] ctrl_word;

  assign ofs     = 4'(addr);
  assign load_wr = wr_en && (ofs == OFS_LOAD);
  assign ctrl_wr = wr_en && (ofs == OFS_CTRL);
  assign clr_wr  = wr_en && (ofs == OFS_CLEAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '0;
      ctrl   <= '0;
    end else begin
      if (load_wr) load_q <= wdata;
      if (ctrl_wr) begin
        ctrl.en       <= wdata[CTRL_EN_BIT];
        ctrl.periodic <= wdata[CTRL_MODE_BIT];
        ctrl.sel      <= wdata[CTRL_SEL_BIT];
      end
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_EN_BIT]   = ctrl.en;
    ctrl_word[CTRL_MODE_BIT] = ctrl.periodic;
    ctrl_word[CTRL_SEL_BIT]  = ctrl.sel;
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (ofs)
        OFS_LOAD:  rd_data = load_q;
        OFS_VALUE: rd_data = count;
        OFS_CTRL:  rd_data = ctrl_word;
        default:   rd_data = '0;
      endcase
    end
  end

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ofs == OFS_CTRL) |-> ((rd_data & ~CTRL_MASK) == '0));
  assert_idle_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));
endmodule

// File: rtl/itimer_counter.sv
module itimer_counter
  import itimer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_ctrl_t         ctrl,
  input  logic              tick_a,
  input  logic              tick_b,
  input  logic              load_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] load_q,
  output logic [DATA_W-1:0] count,
  output logic              zero_evt
);
  logic step, load_now, at_zero;

  assign step     = ctrl.en && (ctrl.sel ? tick_b : tick_a);
  assign load_now = load_wr && ctrl.en;
  assign at_zero  = (count == '0);
  assign zero_evt = step && at_zero && !load_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load_now) begin
      count <= wdata;
    end else if (step) begin
      if (at_zero) count <= ctrl.periodic ? load_q : '1;
      else         count <= count - 1'b1;
    end
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load_now) |=> $stable(count));
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && ctrl.periodic) |=> (count == $past(load_q)));
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && !ctrl.periodic) |=> (count == '1));
  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> (count == $past(wdata)));
endmodule

// File: rtl/itimer_irq.sv
module itimer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_evt,
  input  logic clr_wr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)        irq <= 1'b0;
    else if (zero_evt) irq <= 1'b1;
    else if (clr_wr)   irq <= 1'b0;
  end

  assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> irq);
  assert_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_evt && !clr_wr) |=> $stable(irq));
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !zero_evt) |=> !irq);
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && zero_evt) |=> irq);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itimer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tick_a,
  input  logic              tick_b,
  output logic              irq
);
  logic [DATA_W-1:0] load_q, count;
  tmr_ctrl_t         ctrl;
  logic              load_wr, clr_wr, zero_evt;

  itimer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .count(count), .load_q(load_q), .ctrl(ctrl),
    .load_wr(load_wr), .clr_wr(clr_wr), .rd_data(rd_data)
  );

  itimer_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .tick_a(tick_a), .tick_b(tick_b),
    .load_wr(load_wr), .wdata(wdata), .load_q(load_q), .count(count),
    .zero_evt(zero_evt)
  );

  itimer_irq u_irq (
    .clk(clk), .rst_n(rst_n), .zero_evt(zero_evt), .clr_wr(clr_wr), .irq(irq)
  );
endmodule

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic        tick_a = 1'b0, tick_b = 1'b0;
  logic        irq;
  int checks = 0, fails = 0;
  logic [31:0] rv;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data), .tick_a(tick_a),
    .tick_b(tick_b), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive inputs, pass the edge, release inputs 1 time unit later
  task automatic cyc(bit ta, bit tb, bit w, logic [3:0] a, logic [31:0] d);
    tick_a = ta; tick_b = tb; wr_en = w; addr = a; wdata = d;
    @(posedge clk); #1;
    tick_a = 0; tick_b = 0; wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a);
    rd_en = 1; addr = a; #1;
    rv = rd_data;
    rd_en = 0; #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1; #1;
    // R1: reset state
    rd(4'h0); chk("R1 load", rv, 0);
    rd(4'h4); chk("R1 count", rv, 0);
    rd(4'h8); chk("R1 ctrl", rv, 0);
    chk("R1 irq", 32'(irq), 0);

    // R2: control readback and masking
    cyc(0, 0, 1, 4'h8, 32'hFFFF_FFFF);
    rd(4'h8); chk("R2 ctrl mask", rv, 32'h13);
    cyc(0, 0, 1, 4'h8, 32'h0);
    cyc(0, 0, 1, 4'h0, 32'hA5A5_1234);
    rd(4'h0); chk("R2 load readback", rv, 32'hA5A5_1234);
    rd(4'hC); chk("R2 clear reads zero", rv, 0);
    rd_en = 0; addr = 4'h0; #1; chk("R2 idle read", rd_data, 0);

    // R7 disabled: count unchanged; R3: value not writable
    rd(4'h4); chk("R7 disabled load", rv, 0);
    cyc(0, 0, 1, 4'h4, 32'h55);
    rd(4'h4); chk("R3 value write ignored", rv, 0);

    // R4/R5/R8: sweep reload values and both tick sources
    for (int sel = 0; sel < 2; sel++) begin
      for (int L = 0; L < 8; L++) begin
        cyc(0, 0, 1, 4'h8, 32'h3 | (sel << 4));
        cyc(0, 0, 1, 4'h0, 32'(L));
        cyc(0, 0, 1, 4'hC, 32'h0);
        rd(4'h4); chk("R7 enabled load", rv, 32'(L));
        for (int k = 0; k < L; k++) begin
          cyc(sel == 0, sel == 1, 0, 4'h0, 0);
          cyc(sel == 1, sel == 0, 0, 4'h0, 0);
        end
        rd(4'h4); chk("R4 count after ticks", rv, 0);
        chk("R8 no early irq", 32'(irq), 0);
        cyc(sel == 0, sel == 1, 0, 4'h0, 0);
        chk("R8 irq at zero", 32'(irq), 1);
        rd(4'h4); chk("R5 reload", rv, 32'(L));
        cyc(0, 0, 0, 4'h0, 0);
        chk("R8 irq holds", 32'(irq), 1);
      end
    end

    // R4: disabled ignores ticks
    cyc(0, 0, 1, 4'h8, 32'h2);
    cyc(1, 1, 0, 4'h0, 0);
    rd(4'h4); chk("R4 disabled", rv, 7);

    // R9: clear with arbitrary data
    cyc(0, 0, 1, 4'hC, 32'hDEAD_BEEF);
    chk("R9 clear", 32'(irq), 0);

    // R6: free-running wrap
    cyc(0, 0, 1, 4'h8, 32'h1);
    cyc(0, 0, 1, 4'h0, 32'd2);
    cyc(1, 0, 0, 4'h0, 0);
    cyc(1, 0, 0, 4'h0, 0);
    chk("R6 no irq before wrap", 32'(irq), 0);
    cyc(1, 0, 0, 4'h0, 0);
    rd(4'h4); chk("R6 wrap", rv, 32'hFFFF_FFFF);
    chk("R8 irq on wrap", 32'(irq), 1);
    cyc(1, 0, 0, 4'h0, 0);
    rd(4'h4); chk("R6 decrement after wrap", rv, 32'hFFFF_FFFE);

    // R7: load overrides tick in the same cycle
    cyc(0, 0, 1, 4'hC, 0);
    cyc(0, 0, 1, 4'h0, 32'd0);
    cyc(1, 0, 1, 4'h0, 32'd9);
    rd(4'h4); chk("R7 load beats tick", rv, 9);
    chk("R7 no irq on overridden tick", 32'(irq), 0);

    // R10: set wins over clear
    cyc(0, 0, 1, 4'h8, 32'h3);
    cyc(0, 0, 1, 4'h0, 32'd1);
    cyc(1, 0, 0, 4'h0, 0);
    cyc(1, 0, 1, 4'hC, 32'h0);
    chk("R10 set wins", 32'(irq), 1);
    rd(4'h4); chk("R5 reload after set-wins", rv, 1);
    cyc(0, 0, 1, 4'hC, 32'h1234);
    chk("R9 clear after", 32'(irq), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule